// File: doc/BRIEF.md
# Mode-Selected Multi-Output Clock Divider

This block produces a family of related clock outputs from one fast input clock `clk_i`. Each `clk_i` cycle stands for one half-period of the base clock, so every output is a registered level and divisions by 3 keep exact edges. A single 24-state phase counter drives all output groups. Each group picks its waveform from that counter, so groups whose periods line up rise on the same `clk_i` edge. The groups are host, memory, fixed 66 MHz, peripheral, APIC, 48 MHz and reference.

A two-bit select chooses the behaviour. Code 00 releases the pads and holds every clock low. Code 01 is a test pattern with fixed integer ratios. Codes 10 and 11 are normal operation with a lower or higher host rate. In normal mode the 48 MHz and reference outputs follow externally generated source levels. Memory outputs and peripheral outputs 1 to 7 can each be switched off, and a switch only takes effect at the start of that output's period. An asynchronous active-low power-down clears everything, and a synchronous reset restarts the divider chain from a common phase.

Top module: `clkgen_top`

## Requirements
- R1: With `sel_i` = 00, `pad_oe_o` is low and every clock output is low after each rising edge of `clk_i`.
- R2: With `sel_i` = 01, let p be the output phase (p = 0 on the first output edge after restart, +1 per edge). Then: `ref_clk_o` is high when p mod 2 = 0; host, memory and `u48_clk_o` are high when p mod 4 < 2; `f66_clk_o` is high when p mod 6 < 2; peripheral and APIC outputs are high when p mod 12 < 6.
- R3: With `sel_i` = 10 the host outputs are high when p mod 6 < 2. With `sel_i` = 11 they are high when p mod 4 < 2. In both codes memory is high when p mod 4 < 2, `f66_clk_o` when p mod 6 < 2, and peripheral when p mod 12 < 6.
- R4: `apic_div2_i` is captured on every edge where `rst_i` is high. In codes 10 and 11, a captured 1 makes the APIC outputs high when p mod 24 < 12, and a captured 0 makes them match the peripheral pattern. Changes of `apic_div2_i` while `rst_i` is low have no effect.
- R5: In codes 10 and 11, each `u48_clk_o` bit equals `u48_src_i` and `ref_clk_o` equals `ref_src_i`, both as sampled on the same edge. Before the first output edge after restart both stay low.
- R6: `mem_clk_o[i]` is driven only while `mem_en_i[i]` is 1. `per_clk_o[i]` for i ≥ 1 is driven only while `per_en_i[i]` is 1. A disabled output stays low. `per_en_i[0]` has no effect.
- R7: An enable bit is taken over only on the edge where its output's period starts (p mod 4 = 0 for memory, p mod 12 = 0 for peripheral), so every high pulse has full length.
- R8: While `pd_n_i` is low, all clock outputs are low, with no clock edge needed to clear them. After `pd_n_i` returns high, the third rising edge is the output edge with p = 0.
- R9: While `rst_i` is high, all clock outputs are low. The third rising edge with `rst_i` low is the output edge with p = 0.
- R10: Every rising edge of `per_clk_o[0]` falls on the same `clk_i` edge as a rising edge of `f66_clk_o[0]`, so the 66 MHz group never lags the peripheral group.
- R11: `pad_oe_o` is high whenever `sel_i` is 01, 10 or 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock, one cycle per base half-period |
| rst_i | input | 1 | Synchronous active-high reset |
| pd_n_i | input | 1 | Asynchronous active-low power-down |
| sel_i | input | 2 | Mode select: 00 off, 01 test, 10 low host rate, 11 high host rate |
| apic_div2_i | input | 1 | APIC half-rate strap, captured during reset |
| mem_en_i | input | NMEM (8) | Per-output memory clock enables |
| per_en_i | input | NPER (8) | Peripheral clock enables, bit 0 ignored |
| u48_src_i | input | 1 | Normal-mode 48 MHz source level |
| ref_src_i | input | 1 | Normal-mode reference source level |
| pad_oe_o | output | 1 | Pad drive enable, low means high impedance |
| host_clk_o | output | NHOST (3) | Host clocks |
| mem_clk_o | output | NMEM (8) | Memory clocks |
| f66_clk_o | output | N66 (2) | Fixed 66 MHz group |
| per_clk_o | output | NPER (8) | Peripheral clocks |
| apic_clk_o | output | NAPIC (2) | APIC clocks |
| u48_clk_o | output | N48 (2) | 48 MHz clocks |
| ref_clk_o | output | 1 | Reference clock |

## Verification
The assertions check four things on every edge: the quiet state in select code 00 and in power-down, the phase being zero when the divider restarts, the absence of single-cycle runt pulses on gated outputs, and the 66 MHz group rising together with the peripheral group. Only the bench scenarios can show that each group follows its exact ratio and duty in each select code, and that the captured strap chooses the APIC rate. They also show the precise edge on which a changed enable takes hold, and the three-edge restart latency after reset or power-down.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

    // Phase counter covers the longest period (APIC half rate, 24 half-cycles).
    localparam int unsigned PH_MOD = 24;
    localparam int unsigned PH_W   = $clog2(PH_MOD);

    typedef logic [PH_W-1:0] phase_t;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'b00,
        MODE_TEST = 2'b01,
        MODE_SLOW = 2'b10,
        MODE_FAST = 2'b11
    } mode_e;

    typedef enum logic [2:0] {
        RT_NONE,
        RT_D1,
        RT_D2,
        RT_D3,
        RT_D6,
        RT_D12,
        RT_EXT
    } ratio_e;

    typedef struct packed {
        ratio_e host;
        ratio_e mem;
        ratio_e f66;
        ratio_e per;
        ratio_e apic;
        ratio_e u48;
        ratio_e refc;
    } plan_t;

    // Period of a ratio in half-cycles of the base clock.
    function automatic logic [31:0] half_period(ratio_e r);
        case (r)
            RT_D1:   return 32'd2;
            RT_D2:   return 32'd4;
            RT_D3:   return 32'd6;
            RT_D6:   return 32'd12;
            RT_D12:  return 32'd24;
            default: return 32'd1;
        endcase
    endfunction

    // High time in half-cycles; /3 uses one base period high, two low.
    function automatic logic [31:0] high_len(ratio_e r);
        case (r)
            RT_D1:   return 32'd1;
            RT_D2:   return 32'd2;
            RT_D3:   return 32'd2;
            RT_D6:   return 32'd6;
            RT_D12:  return 32'd12;
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic wave_level(ratio_e r, phase_t ph, logic ext);
        if (r == RT_EXT)  return ext;
        if (r == RT_NONE) return 1'b0;
        return ((32'(ph) % half_period(r)) < high_len(r));
    endfunction

    function automatic logic wave_start(ratio_e r, phase_t ph);
        return ((32'(ph) % half_period(r)) == 32'd0);
    endfunction

    function automatic plan_t decode_plan(mode_e m, logic apic_div2);
        plan_t p;
        p = '{default: RT_NONE};
        case (m)
            MODE_TEST: begin
                p.host = RT_D2;  p.mem  = RT_D2;  p.f66  = RT_D3;
                p.per  = RT_D6;  p.apic = RT_D6;  p.u48  = RT_D2;
                p.refc = RT_D1;
            end
            MODE_SLOW, MODE_FAST: begin
                p.host = (m == MODE_SLOW) ? RT_D3 : RT_D2;
                p.mem  = RT_D2;
                p.f66  = RT_D3;
                p.per  = RT_D6;
                p.apic = apic_div2 ? RT_D12 : RT_D6;
                p.u48  = RT_EXT;
                p.refc = RT_EXT;
            end
            default: p = '{default: RT_NONE};
        endcase
        return p;
    endfunction

endpackage

// File: rtl/clkgen_phase.sv
module clkgen_phase
    import clkgen_pkg::*;
#(
    parameter int unsigned RELEASE_STAGES = 2
) (
    input  logic   clk_i,
    input  logic   rst_i,
    input  logic   pd_n_i,
    output logic   run_o,
    output phase_t ph_o
);

    logic [RELEASE_STAGES-1:0] rel_q;
    phase_t                    ph_q;

    // Release synchronizer: power-down clears it at once, it fills after release.
    always_ff @(posedge clk_i or negedge pd_n_i) begin
        if (!pd_n_i)    rel_q <= '0;
        else if (rst_i) rel_q <= '0;
        else            rel_q <= {rel_q[RELEASE_STAGES-2:0], 1'b1};
    end

    always_ff @(posedge clk_i or negedge pd_n_i) begin
        if (!pd_n_i)                               ph_q <= '0;
        else if (rst_i || !rel_q[RELEASE_STAGES-1]) ph_q <= '0;
        else if (ph_q == phase_t'(PH_MOD - 1))      ph_q <= '0;
        else                                        ph_q <= ph_q + 1'b1;
    end

    assign run_o = rel_q[RELEASE_STAGES-1];
    assign ph_o  = ph_q;

    AST_PHASE_RESTART: assert property (@(posedge clk_i) disable iff (rst_i || !pd_n_i)
        $rose(run_o) |-> (ph_o == '0)); // R8

endmodule

// File: rtl/clkgen_gate.sv
module clkgen_gate
    import clkgen_pkg::*;
#(
    parameter int unsigned WIDTH = 1,
    parameter bit          GATED = 1'b1
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             pd_n_i,
    input  logic             run_i,
    input  ratio_e           ratio_i,
    input  phase_t           ph_i,
    input  logic             ext_i,
    input  logic [WIDTH-1:0] en_i,
    output logic [WIDTH-1:0] clk_o
);

    logic lvl;
    logic start;

    assign lvl   = wave_level(ratio_i, ph_i, ext_i);
    assign start = wave_start(ratio_i, ph_i);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic gate_nxt;

        if (GATED) begin : g_gate
            logic gate_q;
            // Enable is taken over only where the period begins.
            assign gate_nxt = start ? en_i[i] : gate_q;
            always_ff @(posedge clk_i or negedge pd_n_i) begin
                if (!pd_n_i)              gate_q <= 1'b0;
                else if (rst_i || !run_i) gate_q <= 1'b0;
                else                      gate_q <= gate_nxt;
            end
        end else begin : g_open
            logic unused_en;
            assign unused_en = en_i[i];
            assign gate_nxt  = 1'b1;
        end

        always_ff @(posedge clk_i or negedge pd_n_i) begin
            if (!pd_n_i)              clk_o[i] <= 1'b0;
            else if (rst_i || !run_i) clk_o[i] <= 1'b0;
            else                      clk_o[i] <= lvl & gate_nxt;
        end

        AST_NO_RUNT: assert property (@(posedge clk_i) disable iff (rst_i || !pd_n_i)
            ($rose(clk_o[i]) && $stable(ratio_i) && (high_len(ratio_i) >= 32'd2)) |=> clk_o[i]); // R7
    end

endmodule

// File: rtl/clkgen_top.sv
module clkgen_top
    import clkgen_pkg::*;
#(
    parameter int unsigned NHOST          = 3,
    parameter int unsigned NMEM           = 8,
    parameter int unsigned N66            = 2,
    parameter int unsigned NPER           = 8,
    parameter int unsigned NAPIC          = 2,
    parameter int unsigned N48            = 2,
    parameter int unsigned RELEASE_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             pd_n_i,
    input  logic [1:0]       sel_i,
    input  logic             apic_div2_i,
    input  logic [NMEM-1:0]  mem_en_i,
    input  logic [NPER-1:0]  per_en_i,
    input  logic             u48_src_i,
    input  logic             ref_src_i,
    output logic             pad_oe_o,
    output logic [NHOST-1:0] host_clk_o,
    output logic [NMEM-1:0]  mem_clk_o,
    output logic [N66-1:0]   f66_clk_o,
    output logic [NPER-1:0]  per_clk_o,
    output logic [NAPIC-1:0] apic_clk_o,
    output logic [N48-1:0]   u48_clk_o,
    output logic             ref_clk_o
);

    mode_e     mode;
    plan_t     plan;
    logic      strap_q;
    logic      run;
    phase_t    ph;
    logic [NPER-1:0] per_en_eff;
    logic      unused_per0;
    logic      any_clk;

    assign mode = mode_e'(sel_i);

    // APIC rate strap is captured only while reset is held.
    always_ff @(posedge clk_i) begin
        if (rst_i) strap_q <= apic_div2_i;
    end

    assign plan       = decode_plan(mode, strap_q);
    assign pad_oe_o   = (mode != MODE_OFF);
    assign per_en_eff = {per_en_i[NPER-1:1], 1'b1};
    assign unused_per0 = per_en_i[0];

    clkgen_phase #(.RELEASE_STAGES(RELEASE_STAGES)) u_phase (
        .clk_i (clk_i), .rst_i (rst_i), .pd_n_i (pd_n_i),
        .run_o (run),   .ph_o  (ph)
    );

    clkgen_gate #(.WIDTH(NHOST), .GATED(1'b0)) u_host (
        .clk_i (clk_i), .rst_i (rst_i), .pd_n_i (pd_n_i), .run_i (run),
        .ratio_i (plan.host), .ph_i (ph), .ext_i (1'b0),
        .en_i ({NHOST{1'b1}}), .clk_o (host_clk_o)
    );

    clkgen_gate #(.WIDTH(NMEM), .GATED(1'b1)) u_mem (
        .clk_i (clk_i), .rst_i (rst_i), .pd_n_i (pd_n_i), .run_i (run),
        .ratio_i (plan.mem), .ph_i (ph), .ext_i (1'b0),
        .en_i (mem_en_i), .clk_o (mem_clk_o)
    );

    clkgen_gate #(.WIDTH(N66), .GATED(1'b0)) u_f66 (
        .clk_i (clk_i), .rst_i (rst_i), .pd_n_i (pd_n_i), .run_i (run),
        .ratio_i (plan.f66), .ph_i (ph), .ext_i (1'b0),
        .en_i ({N66{1'b1}}), .clk_o (f66_clk_o)
    );

    clkgen_gate #(.WIDTH(NPER), .GATED(1'b1)) u_per (
        .clk_i (clk_i), .rst_i (rst_i), .pd_n_i (pd_n_i), .run_i (run),
        .ratio_i (plan.per), .ph_i (ph), .ext_i (1'b0),
        .en_i (per_en_eff), .clk_o (per_clk_o)
    );

    clkgen_gate #(.WIDTH(NAPIC), .GATED(1'b0)) u_apic (
        .clk_i (clk_i), .rst_i (rst_i), .pd_n_i (pd_n_i), .run_i (run),
        .ratio_i (plan.apic), .ph_i (ph), .ext_i (1'b0),
        .en_i ({NAPIC{1'b1}}), .clk_o (apic_clk_o)
    );

    clkgen_gate #(.WIDTH(N48), .GATED(1'b0)) u_u48 (
        .clk_i (clk_i), .rst_i (rst_i), .pd_n_i (pd_n_i), .run_i (run),
        .ratio_i (plan.u48), .ph_i (ph), .ext_i (u48_src_i),
        .en_i ({N48{1'b1}}), .clk_o (u48_clk_o)
    );

    clkgen_gate #(.WIDTH(1), .GATED(1'b0)) u_ref (
        .clk_i (clk_i), .rst_i (rst_i), .pd_n_i (pd_n_i), .run_i (run),
        .ratio_i (plan.refc), .ph_i (ph), .ext_i (ref_src_i),
        .en_i (1'b1), .clk_o (ref_clk_o)
    );

    assign any_clk = |{host_clk_o, mem_clk_o, f66_clk_o, per_clk_o,
                       apic_clk_o, u48_clk_o, ref_clk_o};

    AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (rst_i || !pd_n_i)
        (sel_i == 2'b00) |=> !any_clk); // R1

    AST_PD_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
        !pd_n_i |-> !any_clk); // R8

    AST_F66_LEADS: assert property (@(posedge clk_i) disable iff (rst_i || !pd_n_i)
        ($rose(per_clk_o[0]) && ($past(sel_i) == $past(sel_i, 2))) |-> $rose(f66_clk_o[0])); // R10

endmodule

// File: tb/clkgen_top_tb.sv
`timescale 1ns/1ps
module clkgen_top_tb;

    logic       clk_i = 1'b0;
    logic       rst_i;
    logic       pd_n_i;
    logic [1:0] sel_i;
    logic       apic_div2_i;
    logic [7:0] mem_en_i;
    logic [7:0] per_en_i;
    logic       u48_src_i;
    logic       ref_src_i;
    logic       pad_oe_o;
    logic [2:0] host_clk_o;
    logic [7:0] mem_clk_o;
    logic [1:0] f66_clk_o;
    logic [7:0] per_clk_o;
    logic [1:0] apic_clk_o;
    logic [1:0] u48_clk_o;
    logic       ref_clk_o;

    int checks = 0;
    int errors = 0;
    int j = 0;
    int cyc = 0;
    bit done = 1'b0;
    bit strap_lat = 1'b0;
    logic [1:0] sel = 2'b00;
    logic [7:0] gmem = '0;
    logic [7:0] gper = '0;

    always #4 clk_i = ~clk_i;

    clkgen_top u_dut (
        .clk_i (clk_i), .rst_i (rst_i), .pd_n_i (pd_n_i), .sel_i (sel_i),
        .apic_div2_i (apic_div2_i), .mem_en_i (mem_en_i), .per_en_i (per_en_i),
        .u48_src_i (u48_src_i), .ref_src_i (ref_src_i), .pad_oe_o (pad_oe_o),
        .host_clk_o (host_clk_o), .mem_clk_o (mem_clk_o), .f66_clk_o (f66_clk_o),
        .per_clk_o (per_clk_o), .apic_clk_o (apic_clk_o), .u48_clk_o (u48_clk_o),
        .ref_clk_o (ref_clk_o)
    );

    function automatic bit lvl(int r, int p);
        return (p % (2 * r)) < ((r == 3) ? 2 : r);
    endfunction

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h (j=%0d)", req, what, act, exp, j);
        end
    endtask

    task automatic check_all(input bit a, input bit b);
        bit run;
        int p;
        int hr;
        int ar;
        string rq;
        logic [2:0] e_host;
        logic [7:0] e_mem;
        logic [7:0] e_per;
        logic [1:0] e_f66;
        logic [1:0] e_apic;
        logic [1:0] e_u48;
        logic       e_ref;
        run = (j >= 3) && (sel != 2'b00) && pd_n_i;
        p   = run ? (j - 3) : 0;
        hr  = (sel == 2'b10) ? 3 : 2;
        ar  = (sel == 2'b01) ? 6 : (strap_lat ? 12 : 6);
        e_host = run ? {3{lvl(hr, p)}} : 3'b000;
        e_mem  = run ? ({8{lvl(2, p)}} & gmem) : 8'h00;
        e_per  = run ? ({8{lvl(6, p)}} & gper) : 8'h00;
        e_f66  = run ? {2{lvl(3, p)}} : 2'b00;
        e_apic = run ? {2{lvl(ar, p)}} : 2'b00;
        e_u48  = !run ? 2'b00 : ((sel == 2'b01) ? {2{lvl(2, p)}} : {2{a}});
        e_ref  = !run ? 1'b0  : ((sel == 2'b01) ? lvl(1, p) : b);
        if (!pd_n_i)           rq = "R8";
        else if (sel == 2'b00) rq = "R1";
        else if (j < 3)        rq = rst_i ? "R9" : "R8/R9";
        else if (sel == 2'b01) rq = "R2";
        else                   rq = "R3";
        chk(rq, "host", {5'd0, host_clk_o}, {5'd0, e_host});
        chk((run ? "R6/R7" : rq), "mem", mem_clk_o, e_mem);
        chk((run ? "R6/R7" : rq), "per", per_clk_o, e_per);
        chk((run ? "R10" : rq), "f66", {6'd0, f66_clk_o}, {6'd0, e_f66});
        chk((run && sel != 2'b01) ? "R4" : rq, "apic", {6'd0, apic_clk_o}, {6'd0, e_apic});
        chk((run && sel != 2'b01) ? "R5" : rq, "u48", {6'd0, u48_clk_o}, {6'd0, e_u48});
        chk((run && sel != 2'b01) ? "R5" : rq, "ref", {7'd0, ref_clk_o}, {7'd0, e_ref});
        chk((sel == 2'b00) ? "R1" : "R11", "pad_oe", {7'd0, pad_oe_o}, {7'd0, (sel != 2'b00)});
    endtask

    // Called at a falling edge; runs n rising edges, checking after each.
    task automatic step(input int n);
        for (int k = 0; k < n; k++) begin
            bit a;
            bit b;
            a = cyc[0] ^ cyc[2];
            b = cyc[1] ^ cyc[3];
            u48_src_i = a;
            ref_src_i = b;
            @(posedge clk_i);
            cyc++;
            if (!rst_i && pd_n_i) j++;
            if (j >= 3) begin
                if (((j - 3) % 4) == 0)  gmem = mem_en_i;
                if (((j - 3) % 12) == 0) gper = per_en_i | 8'h01;
            end
            @(negedge clk_i);
            check_all(a, b);
        end
    endtask

    task automatic do_reset(input logic [1:0] s, input bit st, input logic [7:0] me, input logic [7:0] pe);
        rst_i       = 1'b1;
        sel_i       = s;
        sel         = s;
        apic_div2_i = st;
        mem_en_i    = me;
        per_en_i    = pe;
        j           = 0;
        step(3);
        strap_lat   = st;
        rst_i       = 1'b0;
    endtask

    task automatic power_cycle(input int hold);
        pd_n_i = 1'b0;
        j      = 0;
        #1;
        check_all(1'b0, 1'b0); // R8 immediate clear
        step(hold);
        pd_n_i = 1'b1;
    endtask

    initial begin
        rst_i = 1'b1; pd_n_i = 1'b1; sel_i = 2'b00; apic_div2_i = 1'b0;
        mem_en_i = '0; per_en_i = '0; u48_src_i = 1'b0; ref_src_i = 1'b0;
        @(negedge clk_i);

        // Sweep all select codes and strap values with varied enables.
        for (int s = 0; s < 4; s++) begin
            for (int st = 0; st < 2; st++) begin
                do_reset(2'(s), st[0], 8'(8'h5A ^ (s * 37 + st * 91)), 8'(8'hC6 ^ (s * 53 + st * 17)));
                step(52);
            end
        end

        // R6: peripheral output 0 stays on with its enable bit clear.
        do_reset(2'b11, 1'b0, 8'hFF, 8'h00);
        step(30);

        // R7: enables changed in the middle of periods.
        do_reset(2'b11, 1'b1, 8'hA5, 8'h3C);
        step(9);
        mem_en_i = 8'h5A; per_en_i = 8'hC3;
        step(7);
        mem_en_i = 8'h0F; per_en_i = 8'hF0;
        step(30);

        // R4: strap changes after reset are ignored.
        do_reset(2'b10, 1'b1, 8'hFF, 8'hFF);
        step(10);
        apic_div2_i = 1'b0;
        step(40);

        // R8: power-down mid-run, then restart from a common phase.
        do_reset(2'b01, 1'b0, 8'hFF, 8'hFE);
        step(17);
        power_cycle(5);
        step(40);
        sel_i = 2'b11; sel = 2'b11;
        power_cycle(3);
        step(40);

        // R9: reset mid-run restarts the chain.
        do_reset(2'b10, 1'b0, 8'h33, 8'h99);
        step(40);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1600000;
        if (!done) begin
            errors++;
            $display("FAIL R9 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule